// File: doc/BRIEF.md
# SPI Master Port with Register Bus

This block is a synchronous serial port that runs as an SPI master. Software drives it through a small word-addressed register bus. It sets the clock polarity and phase, the frame length, the serial clock rate and the interrupt mask. It pushes words into an eight-entry transmit queue and pops received words from an eight-entry receive queue. Each transmit word goes out MSB first as one frame. The word captured on the input line during that frame goes into the receive queue.

The serial clock comes from two dividers in series. The first is an even prescaler, written as a byte whose bit 0 always reads as zero. The second is a rate divider of (1 + rate). The serial bit period is therefore prescale × (1 + rate) input clocks.

A loopback bit routes the serial output back to the serial input for self-test. The chip-select line follows a control bit. The interrupt line is the OR of four raw flags gated by a mask:
- transmit queue low
- receive queue high
- receive idle timeout
- receive overrun

Top module: `spim_top`

## Requirements
- R1: Control word 0 (offset 0x00) reads back as written. Its fields are: rate in [15:8], phase in bit 7, polarity in bit 6, a stored format field in [5:4], and frame length minus one in [3:0]. The prescale register (offset 0x10) reads back the written byte with bit 0 forced to zero.
- R2: The status register (offset 0x0C) reads {busy, rx-not-full, rx-not-empty, tx-not-full, tx-empty} in bits [4:0], and reads 0x0B after reset. Busy is high while a frame shifts or the transmit queue holds data.
- R3: While shifting, successive serial clock edges are (prescale/2)×(1+rate) input clocks apart. When no frame is active, the serial clock rests at the polarity bit.
- R4: Data leaves MSB first. With phase 0 it is valid at each leading edge; with phase 1 it is valid at each trailing edge. The leading edge is the edge that leaves the polarity level, and this covers all four polarity/phase modes.
- R5: A frame has (length field + 1) bits, making (length + 1) × 2 clock edges. The received word is right-aligned in the data register (offset 0x08).
- R6: Control word 1 bit 0 set selects loopback, and the serial input pin is then ignored. With it clear, the input pin is sampled.
- R7: Control word 1 bit 1 enables the port; while it is clear, no frame starts. A data write to a full transmit queue (8 entries) is dropped.
- R8: A received frame arriving at a full receive queue is discarded and sets raw bit 0. Writing 1 to bit 0 at offset 0x20 clears that bit.
- R9: Raw bit 1 sets once the receive queue has been non-empty with no push or pop for 64 clocks. Writing 1 to bit 1 at offset 0x20 clears it.
- R10: Raw bit 3 is high when the transmit queue holds 4 or fewer words. Raw bit 2 is high when the receive queue holds 4 or more words. The raw flags are read at offset 0x18.
- R11: The masked set (offset 0x1C) is raw AND mask (offset 0x14). The irq pin is high one cycle after any masked bit is high.
- R12: spi_cs_n is the inverse of control word 1 bit 4 and follows it one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops data on offset 0x08) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after bus_rd |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |
| irq | output | 1 | Combined masked interrupt |

## Verification
Read data appears one cycle after the read strobe. spi_cs_n and irq move one cycle after the register write that changes them. Serial clock edges are spaced by exactly the divider product, and a received word reaches the queue on the final edge of its frame.

The bench drives on falling edges and samples on falling edges. It measures the edge spacing with a cycle counter rather than at fixed instants. It waits for busy to fall before reading results, and it checks registered outputs only after the one-cycle latency has passed.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int FRAME_W = 16;

  localparam logic [5:0] A_CTL0 = 6'h00;
  localparam logic [5:0] A_CTL1 = 6'h04;
  localparam logic [5:0] A_DATA = 6'h08;
  localparam logic [5:0] A_STAT = 6'h0C;
  localparam logic [5:0] A_CPS  = 6'h10;
  localparam logic [5:0] A_MASK = 6'h14;
  localparam logic [5:0] A_RAW  = 6'h18;
  localparam logic [5:0] A_MIS  = 6'h1C;
  localparam logic [5:0] A_CLR  = 6'h20;

  typedef struct packed {
    logic [7:0] rate;
    logic       pha;
    logic       pol;
    logic [1:0] fmt;
    logic [3:0] len_m1;
  } ctl0_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [AW:0]   level,
  output logic          full,
  output logic          empty
);
  localparam logic [AW:0] LVL_FULL = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (level == LVL_FULL);
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      if (do_push && !do_pop)      level <= level + 1'b1;
      else if (do_pop && !do_push) level <= level - 1'b1;
    end
  end
endmodule

// File: rtl/spim_clkdiv.sv
module spim_clkdiv #(
  parameter int PRE_W  = 8,
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [PRE_W-2:0]  half_pre,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  logic [PRE_W-2:0]  pc;
  logic [RATE_W-1:0] sc;
  logic              pc_wrap;

  assign pc_wrap = (pc == half_pre - 1'b1);
  assign tick    = run && pc_wrap && (sc == rate);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pc <= '0;
      sc <= '0;
    end else if (pc_wrap) begin
      pc <= '0;
      sc <= (sc == rate) ? '0 : sc + 1'b1;
    end else begin
      pc <= pc + 1'b1;
    end
  end
endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
  parameter int W  = 16,
  localparam int DW = $clog2(W),
  localparam int EW = DW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          cpol,
  input  logic          cpha,
  input  logic [DW-1:0] len_m1,
  input  logic          tx_avail,
  input  logic [W-1:0]  tx_word,
  input  logic          tick,
  input  logic          rx_in,
  output logic          tx_pop,
  output logic          active,
  output logic          sclk,
  output logic          mosi,
  output logic          rx_push,
  output logic [W-1:0]  rx_word
);
  localparam logic [DW-1:0] TOP = DW'(W-1);

  logic [W-1:0]  tsh, rsh, rsh_n, aligned;
  logic [EW-1:0] ecnt;
  logic          smp;

  assign tx_pop  = !active && en && tx_avail;
  assign aligned = tx_word << (TOP - len_m1);
  assign smp     = (ecnt[0] == cpha);
  assign rsh_n   = smp ? {rsh[W-2:0], rx_in} : rsh;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      sclk    <= 1'b0;
      mosi    <= 1'b0;
      rx_push <= 1'b0;
      rx_word <= '0;
      ecnt    <= '0;
      tsh     <= '0;
      rsh     <= '0;
    end else begin
      rx_push <= 1'b0;
      if (!active) begin
        sclk <= cpol;
        if (tx_pop) begin
          active <= 1'b1;
          ecnt   <= '0;
          rsh    <= '0;
          if (cpha) begin
            tsh <= aligned;
          end else begin
            mosi <= aligned[W-1];
            tsh  <= aligned << 1;
          end
        end
      end else if (tick) begin
        sclk <= ~sclk;
        ecnt <= ecnt + 1'b1;
        rsh  <= rsh_n;
        if (!smp) begin
          mosi <= tsh[W-1];
          tsh  <= tsh << 1;
        end
        if (ecnt == {len_m1, 1'b1}) begin
          active  <= 1'b0;
          rx_push <= 1'b1;
          rx_word <= rsh_n;
        end
      end
    end
  end
endmodule

// File: rtl/spim_top.sv
module spim_top
  import spim_pkg::*;
#(
  parameter int FIFO_DEPTH    = 8,
  parameter int RX_IDLE_LIMIT = 64,
  parameter int PRE_W         = 8,
  localparam int LW           = $clog2(FIFO_DEPTH) + 1,
  localparam int TW           = $clog2(RX_IDLE_LIMIT + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [5:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        spi_cs_n,
  output logic        irq
);
  localparam logic [LW-1:0] LVL_HALF = LW'(FIFO_DEPTH / 2);
  localparam logic [TW-1:0] IDLE_LIM = TW'(RX_IDLE_LIMIT);
  localparam logic [TW-1:0] IDLE_PRE = TW'(RX_IDLE_LIMIT - 1);

  ctl0_t            c0;
  logic [2:0]       c1;      // {cs, en, lb}
  logic [PRE_W-1:1] cps;
  logic [3:0]       imsk;
  logic             ror, rto;
  logic [TW-1:0]    idle_cnt;

  logic wr_data, rd_data, ror_clr, rto_clr;
  logic [FRAME_W-1:0] tx_head, rx_head, rx_word;
  logic [LW-1:0] tx_lvl, rx_lvl;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic tx_pop, rx_push, eng_active, eng_sclk, eng_mosi, tick, rx_in, busy;
  logic [PRE_W-2:0] half_pre;
  logic [3:0] raw;
  logic [4:0] stat;

  assign wr_data  = bus_wr && (bus_addr == A_DATA);
  assign rd_data  = bus_rd && (bus_addr == A_DATA);
  assign ror_clr  = bus_wr && (bus_addr == A_CLR) && bus_wdata[0];
  assign rto_clr  = bus_wr && (bus_addr == A_CLR) && bus_wdata[1];
  assign half_pre = (cps == '0) ? (PRE_W-1)'(1) : cps;
  assign rx_in    = c1[0] ? eng_mosi : spi_miso;
  assign busy     = eng_active || !tx_empty;
  assign stat     = {busy, !rx_full, !rx_empty, !tx_full, tx_empty};
  assign raw      = {tx_lvl <= LVL_HALF, rx_lvl >= LVL_HALF, rto, ror};
  assign spi_sclk = eng_sclk;
  assign spi_mosi = eng_mosi;

  spim_fifo #(.W(FRAME_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .push(wr_data), .wdata(bus_wdata), .pop(tx_pop),
    .rdata(tx_head), .level(tx_lvl), .full(tx_full), .empty(tx_empty));

  spim_fifo #(.W(FRAME_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .push(rx_push), .wdata(rx_word), .pop(rd_data),
    .rdata(rx_head), .level(rx_lvl), .full(rx_full), .empty(rx_empty));

  spim_clkdiv #(.PRE_W(PRE_W), .RATE_W(8)) u_div (
    .clk(clk), .rst(rst), .run(eng_active), .half_pre(half_pre),
    .rate(c0.rate), .tick(tick));

  spim_shift #(.W(FRAME_W)) u_eng (
    .clk(clk), .rst(rst), .en(c1[1]), .cpol(c0.pol), .cpha(c0.pha),
    .len_m1(c0.len_m1), .tx_avail(!tx_empty), .tx_word(tx_head), .tick(tick),
    .rx_in(rx_in), .tx_pop(tx_pop), .active(eng_active), .sclk(eng_sclk),
    .mosi(eng_mosi), .rx_push(rx_push), .rx_word(rx_word));

  always_ff @(posedge clk) begin
    if (rst) begin
      c0       <= '0;
      c1       <= '0;
      cps      <= '0;
      imsk     <= '0;
      ror      <= 1'b0;
      rto      <= 1'b0;
      idle_cnt <= '0;
      spi_cs_n <= 1'b1;
      irq      <= 1'b0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          A_CTL0: c0   <= ctl0_t'(bus_wdata);
          A_CTL1: c1   <= {bus_wdata[4], bus_wdata[1], bus_wdata[0]};
          A_CPS:  cps  <= bus_wdata[PRE_W-1:1];
          A_MASK: imsk <= bus_wdata[3:0];
          default: ;
        endcase
      end
      if (ror_clr) ror <= 1'b0;
      else if (rx_push && rx_full) ror <= 1'b1;
      if (rx_empty || rx_push || rd_data) begin
        idle_cnt <= '0;
      end else if (idle_cnt != IDLE_LIM) begin
        idle_cnt <= idle_cnt + 1'b1;
      end
      if (rto_clr) rto <= 1'b0;
      else if (!rx_empty && !rx_push && !rd_data && idle_cnt == IDLE_PRE) rto <= 1'b1;
      spi_cs_n <= ~c1[2];
      irq      <= |(raw & imsk);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        A_CTL0:  bus_rdata <= c0;
        A_CTL1:  bus_rdata <= {11'b0, c1[2], 2'b00, c1[1], c1[0]};
        A_DATA:  bus_rdata <= rx_head;
        A_STAT:  bus_rdata <= {11'b0, stat};
        A_CPS:   bus_rdata <= {{(16-PRE_W){1'b0}}, cps, 1'b0};
        A_MASK:  bus_rdata <= {12'b0, imsk};
        A_RAW:   bus_rdata <= {12'b0, raw};
        A_MIS:   bus_rdata <= {12'b0, raw & imsk};
        default: bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/spim_chk.sv
module spim_chk #(
  parameter int DEPTH = 8,
  localparam int LW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          active,
  input logic          cpol,
  input logic          sclk,
  input logic          en,
  input logic [LW-1:0] tx_lvl,
  input logic [LW-1:0] rx_lvl,
  input logic          ror,
  input logic          ror_clr,
  input logic          rto,
  input logic          rto_clr
);
  localparam logic [LW-1:0] LVL_FULL = LW'(DEPTH);

  AST_SCLK_REST: assert property (@(posedge clk) disable iff (rst) !active |=> sclk == $past(cpol)); // R3
  AST_NO_START_OFF: assert property (@(posedge clk) disable iff (rst) (!en && !active) |=> !active); // R7
  AST_TXQ_BOUND: assert property (@(posedge clk) disable iff (rst) tx_lvl <= LVL_FULL); // R7
  AST_RXQ_BOUND: assert property (@(posedge clk) disable iff (rst) rx_lvl <= LVL_FULL); // R8
  AST_ROR_HOLD: assert property (@(posedge clk) disable iff (rst) (ror && !ror_clr) |=> ror); // R8
  AST_RTO_HOLD: assert property (@(posedge clk) disable iff (rst) (rto && !rto_clr) |=> rto); // R9
endmodule

bind spim_top spim_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .active(eng_active), .cpol(c0.pol), .sclk(spi_sclk),
  .en(c1[1]), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl), .ror(ror), .ror_clr(ror_clr),
  .rto(rto), .rto_clr(rto_clr));

// File: tb/sim_spim_top.sv
module sim_spim_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] O_CTL0 = 6'h00, O_CTL1 = 6'h04, O_DATA = 6'h08, O_STAT = 6'h0C,
                         O_CPS = 6'h10, O_MASK = 6'h14, O_RAW = 6'h18, O_MIS = 6'h1C,
                         O_CLR = 6'h20;

  logic clk = 0, rst = 1;
  logic [5:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0, spi_miso = 1;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic spi_sclk, spi_mosi, spi_cs_n, irq;

  int total = 0, bad = 0;
  logic mon_clr = 1, cfg_spo = 0, cfg_sph = 0, prev_sclk = 0, have_prev = 0;
  logic [15:0] mon_word = 0;
  int mon_toggles = 0, gap_err = 0, gap_cnt = 0, exp_gap = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  spim_top u0 (.clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs_n(spi_cs_n), .irq(irq));

  // serial monitor: edge spacing, edge count, MOSI at the sampling edge
  always @(negedge clk) begin
    if (mon_clr) begin
      mon_word = 0; mon_toggles = 0; gap_err = 0; have_prev = 0; gap_cnt = 0;
    end else begin
      gap_cnt++;
      if (spi_sclk != prev_sclk) begin
        mon_toggles++;
        if (have_prev && gap_cnt != exp_gap) gap_err++;
        have_prev = 1;
        gap_cnt = 0;
        if ((prev_sclk == cfg_spo) != cfg_sph) mon_word = {mon_word[14:0], spi_mosi};
      end
    end
    prev_sclk = spi_sclk;
  end

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int k = 0; k < 3000; k++) begin
      rd(O_STAT, s);
      if (!s[4]) break;
    end
  endtask

  task automatic pulse_clr();
    @(negedge clk); mon_clr = 1;
    @(negedge clk); mon_clr = 0;
  endtask

  initial begin
    logic [15:0] d, w, msk;
    logic [15:0] wq [10];
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R12 cs_n after reset", spi_cs_n, 1);
    chk("R3 sclk idle after reset", spi_sclk, 0);
    chk("R11 irq after reset", irq, 0);
    rd(O_STAT, d); chk("R2 status after reset", d, 16'h000B);

    // R1 register readback
    wr(O_CTL0, 16'h12C7); rd(O_CTL0, d); chk("R1 ctl0 readback", d, 16'h12C7);
    wr(O_CPS, 16'h0007);  rd(O_CPS, d);  chk("R1 prescale bit0 forced 0", d, 16'h0006);

    // R12 chip select one cycle after write
    wr(O_CTL1, 16'h0010); @(negedge clk); chk("R12 cs_n low", spi_cs_n, 0);
    wr(O_CTL1, 16'h0000); @(negedge clk); chk("R12 cs_n high", spi_cs_n, 1);

    // sweep: 4 modes x 2 lengths x 2 prescales x 2 rates, loopback, miso held high
    spi_miso = 1;
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 2; s++)
        for (int p = 0; p < 2; p++)
          for (int c = 0; c < 2; c++) begin
            logic [3:0] lm1;
            logic [7:0] cpsv, rate;
            lm1 = s ? 4'd15 : 4'd7;
            cpsv = p ? 8'd4 : 8'd2;
            rate = c ? 8'd2 : 8'd0;
            msk = s ? 16'hFFFF : 16'h00FF;
            w = (16'hB38D ^ 16'((m*8 + s*4 + p*2 + c) * 16'h02F1)) & msk;
            cfg_spo = m[1]; cfg_sph = m[0];
            exp_gap = (cpsv / 2) * (1 + rate);
            wr(O_CTL1, 16'h0000);
            wr(O_CTL0, {rate, m[0], m[1], 2'b00, lm1});
            wr(O_CPS, {8'h00, cpsv});
            wr(O_CTL1, 16'h0013);
            pulse_clr();
            wr(O_DATA, w);
            wait_idle();
            rd(O_DATA, d);
            chk($sformatf("R5 R6 loopback word mode%0d len%0d", m, lm1 + 1), d, w);
            chk($sformatf("R4 mosi bits mode%0d len%0d", m, lm1 + 1), mon_word & msk, w);
            chk($sformatf("R3 edge spacing p%0d r%0d", cpsv, rate), gap_err, 0);
            chk($sformatf("R5 edge count len%0d", lm1 + 1), mon_toggles, 2 * (lm1 + 1));
            chk("R3 sclk rests at polarity", spi_sclk, m[1]);
          end

    // R6 pin input with loopback off
    cfg_spo = 0; cfg_sph = 0; exp_gap = 1;
    wr(O_CTL1, 16'h0000); wr(O_CTL0, 16'h0007); wr(O_CPS, 16'h0002);
    wr(O_CTL1, 16'h0012);
    spi_miso = 1; wr(O_DATA, 16'h005A); wait_idle(); rd(O_DATA, d);
    chk("R6 miso high sampled", d, 16'h00FF);
    spi_miso = 0; wr(O_DATA, 16'h00A5); wait_idle(); rd(O_DATA, d);
    chk("R6 miso low sampled", d, 16'h0000);

    // R7 R8 R10 queues, mode 3, port disabled while filling
    cfg_spo = 1; cfg_sph = 1;
    wr(O_CTL1, 16'h0000); wr(O_CTL0, 16'h00C7); wr(O_CTL1, 16'h0001);
    pulse_clr();
    for (int k = 0; k < 10; k++) wq[k] = 16'((8'h30 + k * 8'h11) & 8'hFF);
    for (int k = 0; k < 4; k++) wr(O_DATA, wq[k]);
    rd(O_RAW, d); chk("R10 tx low at 4 words", d[3], 1);
    wr(O_DATA, wq[4]);
    rd(O_RAW, d); chk("R10 tx low clear at 5 words", d[3], 0);
    for (int k = 5; k < 9; k++) wr(O_DATA, wq[k]);
    rd(O_STAT, d); chk("R7 R2 status tx full while disabled", d, 16'h0018);
    repeat (40) @(negedge clk);
    chk("R7 no edges while disabled", mon_toggles, 0);
    chk("R3 sclk rests high while disabled", spi_sclk, 1);
    wr(O_CTL1, 16'h0003);
    wait_idle();
    rd(O_STAT, d); chk("R2 status rx full tx empty", d, 16'h0007);
    rd(O_RAW, d); chk("R10 R8 raw tx/rx/ror", d & 16'h000D, 16'h000C);
    wr(O_DATA, wq[9]); wait_idle();
    rd(O_RAW, d); chk("R8 overrun flag set", d[0], 1);
    for (int k = 0; k < 8; k++) begin
      rd(O_DATA, d);
      chk($sformatf("R7 R8 queued word %0d", k), d, wq[k]);
      if (k == 3) begin rd(O_RAW, d); chk("R10 rx high at 4 words", d[2], 1); end
      if (k == 4) begin rd(O_RAW, d); chk("R10 rx high clear at 3 words", d[2], 0); end
    end
    rd(O_STAT, d); chk("R2 rx empty after drain", d[2], 0);
    wr(O_CLR, 16'h0001); rd(O_RAW, d); chk("R8 overrun cleared", d[0], 0);

    // R9 idle timeout
    wr(O_CLR, 16'h0002);
    wr(O_DATA, 16'h0077);
    for (int k = 0; k < 200; k++) begin rd(O_STAT, d); if (d[2]) break; end
    rd(O_RAW, d); chk("R9 timeout not yet", d[1], 0);
    repeat (80) @(negedge clk);
    rd(O_RAW, d); chk("R9 timeout set", d[1], 1);
    wr(O_CLR, 16'h0002); rd(O_RAW, d); chk("R9 timeout cleared", d[1], 0);
    rd(O_DATA, d); chk("R6 loopback word", d, 16'h0077);

    // R11 masking and irq
    wr(O_MASK, 16'h0008); rd(O_MIS, d); chk("R11 masked tx", d, 16'h0008);
    chk("R11 irq high", irq, 1);
    wr(O_MASK, 16'h0004); rd(O_MIS, d); chk("R11 masked rx off", d, 16'h0000);
    @(negedge clk); chk("R11 irq low", irq, 0);

    summary();
  end
endmodule